// File: doc/BRIEF.md
# Bus-Master DMA Register Front End

This block is the software-facing register set of one bus-master DMA channel. It holds a command byte, a status byte and a descriptor-table base pointer, all reached over a simple byte-lane register bus. Software starts and stops the channel through the start bit of the command byte. Each change of that bit becomes a single-cycle pulse toward the descriptor walker: a restart pulse that reloads the walker's fetch pointer from the base pointer, a kick pulse that wakes an idle channel, or a cancel pulse that aborts a running one.

The status byte carries a DMA-active flag, an error flag and an interrupt flag. The walker reports completion on `walk_done`, with `walk_more` telling whether work is still pending. A walker fault raises the error flag through `walk_err`. The device interrupt line passes through to the host one cycle later, and each rising edge latches the interrupt flag. Software clears the error and interrupt flags by writing ones to them.

There is no streaming data path in this block. All pins are plain control and status levels or pulses, so no valid/ready handshake or back-pressure applies. A register write takes effect on the clock edge at which `bus_we` is sampled high. Read data is combinational from the current register contents.

Top module: `bmdma_regs`

## Requirements
- R1: While `rst_n` is low, the command, status and base registers read as zero, `host_irq` is low and `cancel_o` is held high.
- R2: A command write (`bus_sel`=0, data in `bus_wdata[7:0]`) stores only bit 0 (start) and bit 3 (direction). All other command bits read back as zero.
- R3: A command write whose bit 0 equals the stored start bit produces no kick, restart or cancel pulse and leaves the DMA-active flag unchanged.
- R4: A command write that changes start from 0 to 1 gives a one-cycle `restart_o` in the cycle after the write, with `fetch_base` equal to the base register. If the DMA-active flag (status bit 0) was clear, it is set and a one-cycle `kick_o` is given in that same cycle. If the flag was already set, no kick is given.
- R5: A command write that changes start from 1 to 0 gives a one-cycle `cancel_o` in the cycle after the write and clears the DMA-active flag.
- R6: A base write (`bus_sel`=2) updates only the byte lanes from `bus_off` up to `bus_off`+size-1, where `bus_size` 0, 1 and 2 or 3 mean 1, 2 and 4 bytes. Write byte k comes from `bus_wdata[8k+7:8k]`. Lanes past byte 3 are dropped. Bits 1:0 of the register always stay zero.
- R7: A base read returns the register shifted down by 8*`bus_off` bits. Only the low 1, 2 or 4 bytes given by `bus_size` are kept, and bytes past the register's top read as zero.
- R8: A rising `dev_irq` sets status bit 2 and drives `host_irq` high one cycle later. A falling `dev_irq` lowers `host_irq` one cycle later and leaves status bit 2 unchanged.
- R9: Status writes (`bus_sel`=1) clear bit 1 and bit 2 where the written bit is 1. Bit 0 ignores writes. A set event in the same cycle wins over the clear.
- R10: `walk_done` with `walk_more` high sets the DMA-active flag, and with `walk_more` low clears it. A command write in the same cycle takes precedence.
- R11: `walk_err` sets status bit 1.
- R12: `bus_sel`=3 is unmapped. Writes to it change nothing, and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 command, 1 status, 2 base, 3 unmapped |
| bus_off | input | 2 | Byte offset within the base register |
| bus_size | input | 2 | Access width code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| bus_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for the selected register |
| dev_irq | input | 1 | Interrupt level from the device |
| host_irq | output | 1 | Interrupt level toward the host |
| walk_done | input | 1 | Walker finished a pass |
| walk_more | input | 1 | Walker has more work pending (valid with walk_done) |
| walk_err | input | 1 | Walker fault, sets the error flag |
| kick_o | output | 1 | One-cycle pulse waking an idle walker |
| restart_o | output | 1 | One-cycle pulse reloading the walker fetch pointer |
| cancel_o | output | 1 | One-cycle pulse aborting the transfer; high during reset |
| fetch_base | output | 32 | Descriptor-table base for the walker |

## Verification
Register updates land on the edge that samples a write, and read data is combinational. The bench therefore drives each write on a falling edge and reads back on the next falling edge, a few tenths of a nanosecond later, before the next rising edge. Kick, restart and cancel are registered, so they are due in the single cycle after the write edge. The bench samples them at the falling edge right after that edge. `host_irq` and the interrupt flag are also due one edge after `dev_irq` changes, and they are compared at the same point. Constrained-random operations run against a bench model of all three registers, together with directed cases for partial-lane writes, a repeated start value, a start while already active, and a set racing a write-one-to-clear.

// File: rtl/bmdma_pkg.sv
`timescale 1ns/1ps
package bmdma_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;

  localparam int STAT_ACT = 0;
  localparam int STAT_ERR = 1;
  localparam int STAT_IRQ = 2;
endpackage

// File: rtl/bmdma_cmd.sv
`timescale 1ns/1ps
module bmdma_cmd
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       act_now,
  output logic [7:0] cmd_q,
  output logic       act_set,
  output logic       act_clr,
  output logic       kick_q,
  output logic       restart_q,
  output logic       cancel_q
);
  logic go_up, go_down;

  // Only a change of the start bit triggers an action
  always_comb begin
    go_up   = wr &  wbyte[CMD_START] & ~cmd_q[CMD_START];
    go_down = wr & ~wbyte[CMD_START] &  cmd_q[CMD_START];
    act_set = go_up & ~act_now;
    act_clr = go_down;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      kick_q    <= 1'b0;
      restart_q <= 1'b0;
      cancel_q  <= 1'b0;
    end else begin
      if (wr) cmd_q <= wbyte & CMD_KEEP;
      kick_q    <= act_set;
      restart_q <= go_up;
      cancel_q  <= go_down;
    end
  end
endmodule

// File: rtl/bmdma_status.sv
`timescale 1ns/1ps
module bmdma_status
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       act_set,
  input  logic       act_clr,
  input  logic       walk_done,
  input  logic       walk_more,
  input  logic       walk_err,
  input  logic       dev_irq,
  output logic [7:0] stat_q,
  output logic       host_irq
);
  logic act_r, err_r, irq_r, line_q, line_rise;

  assign line_rise = dev_irq & ~line_q;
  assign stat_q    = {5'b0, irq_r, err_r, act_r};
  assign host_irq  = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_r  <= 1'b0;
      err_r  <= 1'b0;
      irq_r  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      line_q <= dev_irq;
      // register write wins over walker report
      if (act_set)        act_r <= 1'b1;
      else if (act_clr)   act_r <= 1'b0;
      else if (walk_done) act_r <= walk_more;
      // set beats write-one-to-clear
      if (walk_err)                   err_r <= 1'b1;
      else if (wr && wbyte[STAT_ERR]) err_r <= 1'b0;
      if (line_rise)                  irq_r <= 1'b1;
      else if (wr && wbyte[STAT_IRQ]) irq_r <= 1'b0;
    end
  end
endmodule

// File: rtl/bmdma_base.sv
`timescale 1ns/1ps
module bmdma_base #(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int SZ_MAX = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] rdata
);
  logic [OFF_W+1:0]  nb;
  logic [OFF_W+1:0]  lim;
  logic [DATA_W-1:0] wsh, rsh;

  always_comb begin
    if (int'(size) >= SZ_MAX) nb = (OFF_W+2)'(BYTES);
    else                      nb = (OFF_W+2)'(1) << size;
    lim = (OFF_W+2)'(off) + nb;
    wsh = wdata << {off, 3'b000};
    rsh = base_q >> {off, 3'b000};
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    localparam logic [OFF_W+1:0] LI = (OFF_W+2)'(i);
    logic hit;
    assign hit = wr && (LI >= (OFF_W+2)'(off)) && (LI < lim);
    assign rdata[8*i +: 8] = (LI < nb) ? rsh[8*i +: 8] : 8'h00;

    if (i == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (!rst_n)   base_q[7:0] <= 8'h00;
        else if (hit) base_q[7:0] <= {wsh[7:2], 2'b00};
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (!rst_n)   base_q[8*i +: 8] <= 8'h00;
        else if (hit) base_q[8*i +: 8] <= wsh[8*i +: 8];
      end
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
`timescale 1ns/1ps
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dev_irq,
  output logic              host_irq,
  input  logic              walk_done,
  input  logic              walk_more,
  input  logic              walk_err,
  output logic              kick_o,
  output logic              restart_o,
  output logic              cancel_o,
  output logic [DATA_W-1:0] fetch_base
);
  logic [7:0]        cmd_q, stat_q;
  logic [DATA_W-1:0] base_q, base_rd;
  logic              wr_cmd, wr_stat, wr_base;
  logic              act_set, act_clr, cancel_q;

  always_comb begin
    wr_cmd  = bus_we && (reg_sel_e'(bus_sel) == SEL_CMD);
    wr_stat = bus_we && (reg_sel_e'(bus_sel) == SEL_STAT);
    wr_base = bus_we && (reg_sel_e'(bus_sel) == SEL_BASE);
  end

  bmdma_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmd), .wbyte(bus_wdata[7:0]),
    .act_now(stat_q[STAT_ACT]), .cmd_q(cmd_q), .act_set(act_set),
    .act_clr(act_clr), .kick_q(kick_o), .restart_q(restart_o),
    .cancel_q(cancel_q)
  );

  bmdma_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr(wr_stat), .wbyte(bus_wdata[7:0]),
    .act_set(act_set), .act_clr(act_clr), .walk_done(walk_done),
    .walk_more(walk_more), .walk_err(walk_err), .dev_irq(dev_irq),
    .stat_q(stat_q), .host_irq(host_irq)
  );

  bmdma_base #(.DATA_W(DATA_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(wr_base), .off(bus_off),
    .size(bus_size), .wdata(bus_wdata), .base_q(base_q), .rdata(base_rd)
  );

  assign cancel_o   = cancel_q | ~rst_n;
  assign fetch_base = base_q;

  always_comb begin
    unique case (reg_sel_e'(bus_sel))
      SEL_CMD:  bus_rdata = DATA_W'(cmd_q);
      SEL_STAT: bus_rdata = DATA_W'(stat_q);
      SEL_BASE: bus_rdata = base_rd;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bmdma_regs_chk.sv
`timescale 1ns/1ps
module bmdma_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [1:0]  bus_sel,
  input logic [31:0] bus_wdata,
  input logic        dev_irq,
  input logic        host_irq,
  input logic        walk_done,
  input logic        walk_more,
  input logic        kick_o,
  input logic        restart_o,
  input logic        cancel_o,
  input logic [7:0]  cmd_q,
  input logic [7:0]  stat_q,
  input logic [31:0] base_q
);
  // R3
  same_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd0 && bus_wdata[0] == cmd_q[0])
      |=> (!kick_o && !restart_o && !cancel_o));
  // R4
  kick_with_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> (restart_o && stat_q[0]));
  // R5
  cancel_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> !stat_q[0]);
  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |=> (host_irq && stat_q[2]));
  // R6
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00);
  // R10
  walk_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_more && !(bus_we && bus_sel == 2'd0)) |=> stat_q[0]);
  // R2
  cmd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q & 8'hF6) == 8'h00);
endmodule

bind bmdma_regs bmdma_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .dev_irq(dev_irq), .host_irq(host_irq),
  .walk_done(walk_done), .walk_more(walk_more), .kick_o(kick_o),
  .restart_o(restart_o), .cancel_o(cancel_o), .cmd_q(cmd_q),
  .stat_q(stat_q), .base_q(base_q)
);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [1:0]  bus_off = 2'd0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_irq = 1'b0;
  logic        host_irq;
  logic        walk_done = 1'b0, walk_more = 1'b0, walk_err = 1'b0;
  logic        kick_o, restart_o, cancel_o;
  logic [31:0] fetch_base;

  always #2 clk = ~clk;

  bmdma_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_off(bus_off), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dev_irq(dev_irq), .host_irq(host_irq),
    .walk_done(walk_done), .walk_more(walk_more), .walk_err(walk_err),
    .kick_o(kick_o), .restart_o(restart_o), .cancel_o(cancel_o),
    .fetch_base(fetch_base)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0]  m_cmd = 0;
  logic        m_act = 0, m_err = 0, m_irq = 0, m_dev = 0;
  logic [31:0] m_base = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz >= 2) ? 4 : (1 << sz);
  endfunction

  function automatic logic [31:0] base_upd(logic [31:0] old, logic [1:0] off,
                                           logic [1:0] sz, logic [31:0] d);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++)
      if (k >= off && k < off + nbytes(sz)) r[8*k +: 8] = d[8*(k-off) +: 8];
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic logic [31:0] base_view(logic [31:0] b, logic [1:0] off, logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (k < nbytes(sz) && off + k < 4) v[8*k +: 8] = b[8*(off+k) +: 8];
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(logic [1:0] sel, logic [1:0] off, logic [1:0] sz, output logic [31:0] v);
    bus_sel = sel; bus_off = off; bus_size = sz;
    #0.1;
    v = bus_rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    rd(2'd0, 2'd0, 2'd0, v); chk(req, "cmd", v, {24'b0, m_cmd});
    rd(2'd1, 2'd0, 2'd0, v); chk(req, "status", v, {29'b0, m_irq, m_err, m_act});
    rd(2'd2, 2'd0, 2'd2, v); chk(req, "base", v, m_base);
    chk(req, "fetch_base", fetch_base, m_base);
    chk("R8", "host_irq", {31'b0, host_irq}, {31'b0, m_dev});
  endtask

  task automatic wr(string req, logic [1:0] sel, logic [1:0] off, logic [1:0] sz, logic [31:0] d);
    logic ek = 0, er = 0, ec = 0;
    case (sel)
      2'd0: begin
        er = d[0] & ~m_cmd[0];
        ec = ~d[0] & m_cmd[0];
        ek = er & ~m_act;
        if (er) m_act = 1;
        if (ec) m_act = 0;
        m_cmd = d[7:0] & 8'h09;
      end
      2'd1: begin
        if (d[1]) m_err = 0;
        if (d[2]) m_irq = 0;
      end
      2'd2: m_base = base_upd(m_base, off, sz, d);
      default: ;
    endcase
    bus_we = 1; bus_sel = sel; bus_off = off; bus_size = sz; bus_wdata = d;
    step();
    bus_we = 0;
    chk(req, "kick", {31'b0, kick_o}, {31'b0, ek});
    chk(req, "restart", {31'b0, restart_o}, {31'b0, er});
    chk(req, "cancel", {31'b0, cancel_o}, {31'b0, ec});
    check_all(req);
  endtask

  task automatic irq(logic v);
    if (v & ~m_dev) m_irq = 1;
    m_dev = v;
    dev_irq = v;
    step();
    check_all("R8");
  endtask

  task automatic walk(logic dn, logic more, logic err);
    walk_done = dn; walk_more = more; walk_err = err;
    if (err) m_err = 1;
    if (dn) m_act = more;
    step();
    walk_done = 0; walk_more = 0; walk_err = 0;
    check_all(err ? "R11" : "R10");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2718));
    @(negedge clk); step();
    // R1 reset state
    chk("R1", "cancel in reset", {31'b0, cancel_o}, 32'd1);
    chk("R1", "host_irq in reset", {31'b0, host_irq}, 32'd0);
    check_all("R1");
    rst_n = 1;
    step();
    chk("R1", "cancel after reset", {31'b0, cancel_o}, 32'd0);

    // R6 / R7 base lanes
    wr("R6", 2'd2, 2'd0, 2'd2, 32'hFFFF_FFFF);
    wr("R6", 2'd2, 2'd1, 2'd0, 32'h0000_005A);
    wr("R6", 2'd2, 2'd2, 2'd1, 32'h0000_1234);
    wr("R6", 2'd2, 2'd0, 2'd0, 32'h0000_00FF);
    wr("R6", 2'd2, 2'd3, 2'd1, 32'h0000_ABCD);
    rd(2'd2, 2'd3, 2'd0, v); chk("R7", "base off3 b1", v, base_view(m_base, 2'd3, 2'd0));
    rd(2'd2, 2'd2, 2'd2, v); chk("R7", "base off2 b4", v, base_view(m_base, 2'd2, 2'd2));
    rd(2'd2, 2'd1, 2'd1, v); chk("R7", "base off1 b2", v, base_view(m_base, 2'd1, 2'd1));

    // R2 R4 R3 R5
    wr("R2", 2'd0, 2'd0, 2'd0, 32'h0000_00FF);
    wr("R3", 2'd0, 2'd0, 2'd0, 32'h0000_0001);
    wr("R5", 2'd0, 2'd0, 2'd0, 32'h0000_0008);
    walk(1'b1, 1'b1, 1'b0);
    wr("R4", 2'd0, 2'd0, 2'd0, 32'h0000_0001);
    walk(1'b1, 1'b0, 1'b0);
    wr("R3", 2'd0, 2'd0, 2'd0, 32'h0000_00F7);

    // R11 R9
    walk(1'b0, 1'b0, 1'b1);
    wr("R9", 2'd1, 2'd0, 2'd0, 32'h0000_0001);
    irq(1'b1);
    irq(1'b0);
    wr("R9", 2'd1, 2'd0, 2'd0, 32'h0000_0006);
    // R9 set beats clear in the same cycle
    m_dev = 1; m_irq = 1; dev_irq = 1;
    bus_we = 1; bus_sel = 2'd1; bus_wdata = 32'h4;
    step();
    bus_we = 0;
    check_all("R9");
    irq(1'b0);

    // R12 unmapped select
    wr("R12", 2'd3, 2'd0, 2'd2, 32'hFFFF_FFFF);
    rd(2'd3, 2'd0, 2'd2, v); chk("R12", "unmapped read", v, 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0, 1: wr("R4", 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 2'($urandom_range(0, 3)), $urandom());
        2: wr("R3", 2'd0, 2'd0, 2'd0, {$urandom() & 32'hFE, m_cmd[0]});
        3: irq(~m_dev);
        4: walk(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
        default: begin
          logic [1:0] o = 2'($urandom_range(0, 3));
          logic [1:0] s = 2'($urandom_range(0, 3));
          rd(2'd2, o, s, v); chk("R7", "base random read", v, base_view(m_base, o, s));
        end
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule